// File: doc/BRIEF.md
# Character Serializer with Internal Loopback

The block turns one 10-bit line-coded character per frame into a serial stream of ten bits. It runs on a bit-rate clock. A one-cycle character strobe, asserted once every ten bit clocks, stands in for the rising edge of the reference clock. On a strobe cycle the parallel character is captured. At a fixed point in the frame it moves into a shift register, and the bits then leave least significant first, bit 0 (line bit `a`) through bit 9 (line bit `j`).

The serial stream always appears on a loopback output that feeds the local receiver. A loopback control picks what the line output carries. With the control low, the line output carries the serial stream. With it high, the line output is held at a static level (true leg high, complement leg low), and the data reaches only the loopback path.

If no strobe arrives, the frame counter keeps wrapping every ten clocks and the last captured character is sent again in each frame. A strobe in the middle of a frame restarts the frame at that cycle.

Top module: `ser_loop_tx`

## Requirements
- R1: While reset is held and after it is released, before the first strobe, `line_p_o` and `loop_o` are 0 and `line_n_o` is 1.
- R2: `char_i` is sampled only on a clock edge where `char_stb_i` is 1. Its value at any other edge has no effect on the serial stream.
- R3: Bit order is bit 0 first, then bit 1 and so on up to bit 9, one bit per clock.
- R4: Counting the capture edge as edge 0, bit 0 of the character is on the serial outputs from edge 7 (parameter `LATENCY`) until edge 8. Bit k is on the outputs from edge 7+k.
- R5: With a strobe every 10 clocks, consecutive characters follow one another with no idle or repeated bit between them.
- R6: While `loop_en_i` is 1, `line_p_o` is 1 and `line_n_o` is 0, whatever data is being sent.
- R7: `loop_o` carries the serial stream whatever the value of `loop_en_i`, including when `loop_en_i` changes in mid-character.
- R8: While `loop_en_i` is 0, `line_p_o` equals the serial bit and `line_n_o` is its complement.
- R9: With no further strobe, the last captured character is sent again every 10 clocks with the same bit order and phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bit-rate clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| char_stb_i | input | 1 | Character strobe, one cycle in ten |
| char_i | input | 10 | Coded character; bit 0 is sent first |
| loop_en_i | input | 1 | 1 = loopback: line output held static |
| line_p_o | output | 1 | Serial line output, true leg |
| line_n_o | output | 1 | Serial line output, complement leg |
| loop_o | output | 1 | Serial loopback output to local receiver |

## Verification
The assertions assume that the strobe lasts exactly one clock and that the loopback control is a level that can change on any cycle. The hold-register check also assumes the character input may change freely between strobes. The bench drives every input one nanosecond after a rising edge. It keeps the strobe to single cycles, normally ten clocks apart. Between strobes it puts a different character on the input, so that sampling off the strobe would show up in the stream. It also toggles the loopback control on every cycle in one stream to exercise the mid-character case.

// File: rtl/ser_pkg.sv
package ser_pkg;
  parameter int unsigned CHAR_W_DEF  = 10;
  parameter int unsigned LATENCY_DEF = 7;
  // Static levels of the line pair while looped back
  parameter logic LOOP_LINE_P = 1'b1;
endpackage

// File: rtl/ser_char_capture.sv
module ser_char_capture #(
  parameter int unsigned CHAR_W = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              stb_i,
  input  logic [CHAR_W-1:0] char_i,
  output logic [CHAR_W-1:0] hold_o
);
  logic [CHAR_W-1:0] hold_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    hold_q <= '0;
    else if (stb_i) hold_q <= char_i;
  end

  assign hold_o = hold_q;

  // R2: the held character changes only after a strobe
  a_r2_hold_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !stb_i |=> $stable(hold_q));
endmodule

// File: rtl/ser_frame_ctr.sv
module ser_frame_ctr #(
  parameter int unsigned FRAME   = 10,
  parameter int unsigned LOAD_AT = 6
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic stb_i,
  output logic load_o
);
  localparam int unsigned CNT_W = (FRAME > 1) ? $clog2(FRAME) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(FRAME - 1);
  localparam logic [CNT_W-1:0] LOAD = CNT_W'(LOAD_AT);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (stb_i)         cnt_q <= '0;
    else if (cnt_q == LAST) cnt_q <= '0;
    else                    cnt_q <= cnt_q + 1'b1;
  end

  assign load_o = (cnt_q == LOAD);

  // R5: the phase never leaves the frame
  a_r5_phase_in_frame: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LAST);
endmodule

// File: rtl/ser_shifter.sv
module ser_shifter #(
  parameter int unsigned CHAR_W = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [CHAR_W-1:0] data_i,
  output logic              ser_o
);
  logic [CHAR_W-1:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     sh_q <= '0;
    else if (load_i) sh_q <= data_i;
    else             sh_q <= {1'b0, sh_q[CHAR_W-1:1]};
  end

  // Bit 0 leaves first
  assign ser_o = sh_q[0];
endmodule

// File: rtl/ser_loop_tx.sv
module ser_loop_tx #(
  parameter int unsigned CHAR_W  = ser_pkg::CHAR_W_DEF,
  parameter int unsigned LATENCY = ser_pkg::LATENCY_DEF
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              char_stb_i,
  input  logic [CHAR_W-1:0] char_i,
  input  logic              loop_en_i,
  output logic              line_p_o,
  output logic              line_n_o,
  output logic              loop_o
);
  // Edge that loads the shifter is LATENCY-1 edges after capture
  localparam int unsigned LOAD_AT = LATENCY - 1;

  logic [CHAR_W-1:0] hold;
  logic              load;
  logic              ser;

  ser_char_capture #(.CHAR_W(CHAR_W)) u_cap (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .stb_i  (char_stb_i),
    .char_i (char_i),
    .hold_o (hold)
  );

  ser_frame_ctr #(.FRAME(CHAR_W), .LOAD_AT(LOAD_AT)) u_ctr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .stb_i  (char_stb_i),
    .load_o (load)
  );

  ser_shifter #(.CHAR_W(CHAR_W)) u_sh (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (load),
    .data_i (hold),
    .ser_o  (ser)
  );

  assign loop_o   = ser;
  assign line_p_o = loop_en_i ? ser_pkg::LOOP_LINE_P : ser;
  assign line_n_o = ~line_p_o;

  // R3: first bit after a load is bit 0 of the held character
  a_r3_first_bit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(load) |-> loop_o == $past(hold[0]));

  // R7: loopback output follows the line whenever the line is not parked
  a_r7_loop_tracks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !loop_en_i |-> loop_o == line_p_o);

  // R8: the two legs are always complementary
  a_r8_legs_differ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    line_p_o != line_n_o);

  // R6: looped back means true leg high
  a_r6_line_parked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    loop_en_i |-> line_p_o);
endmodule

// File: tb/ser_loop_tx_test.sv
`timescale 1ns/1ps
module ser_loop_tx_test;
  localparam int W = 10;
  localparam int LAT = 7;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic stb = 1'b0;
  logic [W-1:0] chr = '0;
  logic loop_en = 1'b0;
  logic line_p, line_n, loop_s;

  int n_tests = 0;
  int n_fail = 0;
  logic [W-1:0] chars [4];

  always #2 clk = ~clk;

  ser_loop_tx uut (
    .clk_i(clk), .rst_ni(rst_n), .char_stb_i(stb), .char_i(chr),
    .loop_en_i(loop_en), .line_p_o(line_p), .line_n_o(line_n), .loop_o(loop_s)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // Streams n chars (strobe every 10 clocks), runs cyc edges total.
  // mode: 0 loop off, 1 loop on, 2 loop toggles every cycle.
  task automatic run_stream(input int n, input int cyc, input int mode, input string req);
    for (int t = 0; t < cyc; t++) begin
      stb = (t % 10 == 0) && (t / 10 < n);
      chr = stb ? chars[t / 10] : ~chars[(t / 10 < n) ? t / 10 : n - 1]; // R2 decoy
      loop_en = (mode == 2) ? t[0] : (mode == 1);
      @(posedge clk);
      #1;
      stb = 1'b0;
      loop_en = (mode == 2) ? t[0] : (mode == 1);
      if (t >= LAT) begin
        int m = (t - LAT) / 10;
        int k = (t - LAT) % 10;
        logic b;
        if (m >= n) m = n - 1;
        b = chars[m][k];
        chk(loop_s == b, {req, " loop_o"}, loop_s, b);
        if (loop_en) chk(line_p == 1'b1 && line_n == 1'b0, "R6 line parked", line_p, 1);
        else chk(line_p == b && line_n == ~b, {req, " R8 line_p"}, line_p, b);
      end
    end
  endtask

  task automatic t_reset;
    chk(line_p == 0 && loop_s == 0 && line_n == 1, "R1 in reset", line_p, 0);
    @(posedge clk); #1 rst_n = 1'b1;
    for (int i = 0; i < 20; i++) begin
      @(posedge clk); #1;
      chk(line_p == 0 && loop_s == 0 && line_n == 1, "R1 idle", line_p, 0);
    end
  endtask

  task automatic t_order;
    chars[0] = 10'b1010_11_1100; // bits 0..9 = 0,0,1,1,1,1,0,1,0,1
    run_stream(1, 17, 0, "R3 R4 order");
  endtask

  task automatic t_stream;
    chars[0] = 10'h17C; chars[1] = 10'h283; chars[2] = 10'h3FF; chars[3] = 10'h001;
    run_stream(4, 47, 0, "R5 R2 stream");
  endtask

  task automatic t_loop_on;
    chars[0] = 10'h2AA; chars[1] = 10'h155;
    run_stream(2, 27, 1, "R6 R7 loop on");
  endtask

  task automatic t_loop_toggle;
    chars[0] = 10'h0F3; chars[1] = 10'h30C; chars[2] = 10'h1E1;
    run_stream(3, 37, 2, "R7 R8 toggle");
  endtask

  task automatic t_repeat;
    chars[0] = 10'h2C7;
    run_stream(1, 47, 0, "R9 repeat");
  endtask

  initial begin
    #400000;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #1;
    t_reset();
    t_order();
    t_stream();
    t_loop_on();
    t_loop_toggle();
    t_repeat();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule